// File: doc/BRIEF.md
# Banked General Register File and Status Word

This block stores the sixteen general-purpose registers and the packed status word of a small processor core. It also keeps the program-counter, exception-vector-base and floating-point-control registers with their power-on values. The eight lowest registers exist twice. The status word's bank-select bit chooses which copy the read and write ports reach. When a status write changes that bit, the other copy becomes visible. The upper eight registers have one copy and are shared by both views.

The four condition flags (carry/test, saturate, quotient and sign-of-divisor) are held in separate flops so that datapath logic can reach them directly. They are loaded from their fixed positions on every status write, and they are merged back into those positions whenever the status word is read. A one-cycle pulse reports each change of visible bank. The floating-point register half in use follows one bit of the floating-point control register. A small control port lets the core load the vector base, the floating-point control word and the next program counter. Instruction decode and arithmetic are outside this block.

Top module: `bankreg_core`

## Requirements
- R1: A status write whose bit 29 differs from the current bank-select bit makes R0..R7 reads return the other copy from the next cycle on; the previously visible copy is kept intact and comes back on the next change.
- R2: A status write whose bit 29 equals the current bank-select bit leaves the visible copy of R0..R7 unchanged.
- R3: R8..R15 have one copy; their values read the same under either bank-select value.
- R4: When a general-register write to R0..R7 and a bank-changing status write happen in the same cycle, the data goes to the copy that was visible before the change.
- R5: Flags T (bit 0), S (bit 1), Q (bit 8) and M (bit 9) are loaded from the written status word on every status write, and a status read returns them in those positions.
- R6: A status read returns every other written bit unchanged, including bank select (bit 29), privileged mode (bit 30) and interrupt block (bit 28). The value holds until the next status write.
- R7: After reset the status word and all general registers read 0, the vector base reads 0x00000000, the floating-point control word reads 0x00040001, the next program counter reads 0xA0000002 and the program counter reads 0xA0000000.
- R8: The floating-point bank output equals bit 21 of the floating-point control word.
- R9: The bank-swap output is high in the cycle after a bank-changing status write and low after any cycle without one.
- R10: A control write with select 0 loads the vector base, select 1 loads the floating-point control word and select 2 loads the next program counter. The program counter output is always the next program counter minus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| gpr_we | input | 1 | General-register write enable |
| gpr_waddr | input | 4 | General-register write index |
| gpr_wdata | input | 32 | General-register write data |
| gpr_raddr | input | 4 | General-register read index |
| gpr_rdata | output | 32 | General-register read data (combinational) |
| sr_we | input | 1 | Status-word write enable |
| sr_wdata | input | 32 | Status-word write data |
| sr_rdata | output | 32 | Status word with flags merged |
| ctl_we | input | 1 | Control-register write enable |
| ctl_sel | input | 2 | Control-register select: 0 vector base, 1 FP control, 2 next PC |
| ctl_wdata | input | 32 | Control-register write data |
| pc_o | output | 32 | Program counter |
| npc_o | output | 32 | Next program counter |
| vbr_o | output | 32 | Vector base |
| fpscr_o | output | 32 | Floating-point control word |
| fp_bank_o | output | 1 | Active floating-point register half |
| bank_swap_o | output | 1 | Pulse: visible bank changed |

## Verification
On every cycle, the assertions check the following: the swap pulse against the compared bank bit, the flag capture on status writes, that the status word and control registers stay stable when idle, that the upper registers stay stable, and that a same-cycle register write lands in the old bank. Only the bench's scenarios can show the full round trip: data written under one bank survives a swap, reappears on the swap back, and is never seen through the other view. The same holds for the reset values and for the program-counter offset after a load.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int XLEN = 32;

  // Status word bit positions
  localparam int SR_T_BIT  = 0;
  localparam int SR_S_BIT  = 1;
  localparam int SR_Q_BIT  = 8;
  localparam int SR_M_BIT  = 9;
  localparam int SR_BL_BIT = 28;
  localparam int SR_RB_BIT = 29;
  localparam int SR_MD_BIT = 30;

  localparam int FP_BANK_BIT = 21;

  localparam logic [XLEN-1:0] RST_VBR   = 32'h0000_0000;
  localparam logic [XLEN-1:0] RST_FPSCR = 32'h0004_0001;
  localparam logic [XLEN-1:0] RST_NPC   = 32'hA000_0002;
  localparam logic [XLEN-1:0] PC_STEP   = 32'd2;

  typedef enum logic [1:0] {
    CSEL_VBR   = 2'd0,
    CSEL_FPSCR = 2'd1,
    CSEL_NPC   = 2'd2,
    CSEL_NONE  = 2'd3
  } ctl_sel_e;
endpackage

// File: rtl/bankreg_gpr.sv
module bankreg_gpr #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int NLOW = 8,
  localparam int AW  = $clog2(NREG),
  localparam int LAW = $clog2(NLOW),
  localparam int NHI = NREG - NLOW,
  localparam int HAW = (NHI > 1) ? $clog2(NHI) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bank_sel,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  logic [1:0][NLOW-1:0][XLEN-1:0] low_q;
  logic [NHI-1:0][XLEN-1:0]       hi_q;
  logic [1:0][NLOW-1:0]           low_en;
  logic [NHI-1:0]                 hi_en;
  logic [AW-1:0]                  w_hoff, r_hoff;
  logic                           w_is_low, r_is_low;

  assign w_is_low = (waddr < AW'(NLOW));
  assign r_is_low = (raddr < AW'(NLOW));
  assign w_hoff   = waddr - AW'(NLOW);
  assign r_hoff   = raddr - AW'(NLOW);

  // Write enables: low writes target the currently visible copy
  always_comb begin
    low_en = '0;
    hi_en  = '0;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < NLOW; i++) begin
        low_en[b][i] = we && w_is_low && (waddr[LAW-1:0] == LAW'(i)) && (bank_sel == b[0]);
      end
    end
    for (int j = 0; j < NHI; j++) begin
      hi_en[j] = we && !w_is_low && (w_hoff[HAW-1:0] == HAW'(j));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      hi_q  <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < NLOW; i++) begin
          if (low_en[b][i]) low_q[b][i] <= wdata;
        end
      end
      for (int j = 0; j < NHI; j++) begin
        if (hi_en[j]) hi_q[j] <= wdata;
      end
    end
  end

  always_comb begin
    if (r_is_low) rdata = low_q[bank_sel][raddr[LAW-1:0]];
    else          rdata = hi_q[r_hoff[HAW-1:0]];
  end

  // Checker state: remember last low write to verify where it landed
  logic            chk_vld_q;
  logic            chk_bank_q;
  logic [LAW-1:0]  chk_idx_q;
  logic [XLEN-1:0] chk_data_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld_q  <= 1'b0;
      chk_bank_q <= 1'b0;
      chk_idx_q  <= '0;
      chk_data_q <= '0;
    end else begin
      chk_vld_q  <= we && w_is_low;
      chk_bank_q <= bank_sel;
      chk_idx_q  <= waddr[LAW-1:0];
      chk_data_q <= wdata;
    end
  end

  // R4: a low write lands in the copy visible when it was issued
  assert_write_old_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld_q |-> low_q[chk_bank_q][chk_idx_q] == chk_data_q);

  // R3: unbanked registers change only on their own writes
  assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && !w_is_low) |=> $stable(hi_q));

  // R1: the hidden copy is untouched while hidden
  assert_hidden_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel |=> $stable(low_q[0]));
endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
  import bankreg_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sr_we,
  input  logic [W-1:0] sr_wdata,
  output logic [W-1:0] sr_rdata,
  output logic         bank_sel,
  output logic         swap_o
);
  localparam logic [W-1:0] FLAG_MASK =
    (W'(1) << SR_T_BIT) | (W'(1) << SR_S_BIT) | (W'(1) << SR_Q_BIT) | (W'(1) << SR_M_BIT);

  logic [W-1:0] word_q, word_d;
  logic         t_q, s_q, q_q, m_q;
  logic         t_d, s_d, q_d, m_d;
  logic         swap_q, swap_d;
  logic [W-1:0] flag_vec;

  always_comb begin
    word_d = word_q;
    t_d    = t_q;
    s_d    = s_q;
    q_d    = q_q;
    m_d    = m_q;
    swap_d = 1'b0;
    if (sr_we) begin
      word_d = sr_wdata;
      t_d    = sr_wdata[SR_T_BIT];
      s_d    = sr_wdata[SR_S_BIT];
      q_d    = sr_wdata[SR_Q_BIT];
      m_d    = sr_wdata[SR_M_BIT];
      swap_d = sr_wdata[SR_RB_BIT] ^ word_q[SR_RB_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      t_q    <= 1'b0;
      s_q    <= 1'b0;
      q_q    <= 1'b0;
      m_q    <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      word_q <= word_d;
      t_q    <= t_d;
      s_q    <= s_d;
      q_q    <= q_d;
      m_q    <= m_d;
      swap_q <= swap_d;
    end
  end

  // Read: clear flag slots, then re-insert flags held apart
  always_comb begin
    flag_vec = '0;
    flag_vec[SR_T_BIT] = t_q;
    flag_vec[SR_S_BIT] = s_q;
    flag_vec[SR_Q_BIT] = q_q;
    flag_vec[SR_M_BIT] = m_q;
  end
  assign sr_rdata = (word_q & ~FLAG_MASK) | flag_vec;
  assign bank_sel = word_q[SR_RB_BIT];
  assign swap_o   = swap_q;

  assert_swap_on_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we && (sr_wdata[SR_RB_BIT] != bank_sel) |=> swap_o && (bank_sel == $past(sr_wdata[SR_RB_BIT])));

  assert_no_swap_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we && (sr_wdata[SR_RB_BIT] == bank_sel) |=> !swap_o && $stable(bank_sel));

  assert_swap_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we |=> !swap_o);

  assert_flags_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> (sr_rdata[SR_T_BIT] == $past(sr_wdata[SR_T_BIT])) &&
              (sr_rdata[SR_S_BIT] == $past(sr_wdata[SR_S_BIT])) &&
              (sr_rdata[SR_Q_BIT] == $past(sr_wdata[SR_Q_BIT])) &&
              (sr_rdata[SR_M_BIT] == $past(sr_wdata[SR_M_BIT])));

  assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we |=> $stable(sr_rdata));
endmodule

// File: rtl/bankreg_ctl.sv
module bankreg_ctl
  import bankreg_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  ctl_sel_e     ctl_sel,
  input  logic [W-1:0] ctl_wdata,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] npc_o,
  output logic [W-1:0] vbr_o,
  output logic [W-1:0] fpscr_o,
  output logic         fp_bank_o
);
  logic [W-1:0] vbr_q, fpscr_q, npc_q;
  logic         vbr_en, fpscr_en, npc_en;

  assign vbr_en   = ctl_we && (ctl_sel == CSEL_VBR);
  assign fpscr_en = ctl_we && (ctl_sel == CSEL_FPSCR);
  assign npc_en   = ctl_we && (ctl_sel == CSEL_NPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbr_q   <= RST_VBR;
      fpscr_q <= RST_FPSCR;
      npc_q   <= RST_NPC;
    end else begin
      if (vbr_en)   vbr_q   <= ctl_wdata;
      if (fpscr_en) fpscr_q <= ctl_wdata;
      if (npc_en)   npc_q   <= ctl_wdata;
    end
  end

  assign vbr_o     = vbr_q;
  assign fpscr_o   = fpscr_q;
  assign npc_o     = npc_q;
  assign pc_o      = npc_q - PC_STEP;
  assign fp_bank_o = fpscr_q[FP_BANK_BIT];

  assert_fp_bank_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fpscr_en |=> fp_bank_o == $past(ctl_wdata[FP_BANK_BIT]));

  assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(vbr_o) && $stable(fpscr_o) && $stable(npc_o));
endmodule

// File: rtl/bankreg_core.sv
module bankreg_core
  import bankreg_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NLOW = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gpr_we,
  input  logic [AW-1:0]   gpr_waddr,
  input  logic [XLEN-1:0] gpr_wdata,
  input  logic [AW-1:0]   gpr_raddr,
  output logic [XLEN-1:0] gpr_rdata,
  input  logic            sr_we,
  input  logic [XLEN-1:0] sr_wdata,
  output logic [XLEN-1:0] sr_rdata,
  input  logic            ctl_we,
  input  logic [1:0]      ctl_sel,
  input  logic [XLEN-1:0] ctl_wdata,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] vbr_o,
  output logic [XLEN-1:0] fpscr_o,
  output logic            fp_bank_o,
  output logic            bank_swap_o
);
  logic     bank_sel;
  ctl_sel_e sel_e;

  assign sel_e = ctl_sel_e'(ctl_sel);

  bankreg_status #(.W(XLEN)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_we    (sr_we),
    .sr_wdata (sr_wdata),
    .sr_rdata (sr_rdata),
    .bank_sel (bank_sel),
    .swap_o   (bank_swap_o)
  );

  bankreg_gpr #(.XLEN(XLEN), .NREG(NREG), .NLOW(NLOW)) u_gpr (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_sel (bank_sel),
    .we       (gpr_we),
    .waddr    (gpr_waddr),
    .wdata    (gpr_wdata),
    .raddr    (gpr_raddr),
    .rdata    (gpr_rdata)
  );

  bankreg_ctl #(.W(XLEN)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_sel   (sel_e),
    .ctl_wdata (ctl_wdata),
    .pc_o      (pc_o),
    .npc_o     (npc_o),
    .vbr_o     (vbr_o),
    .fpscr_o   (fpscr_o),
    .fp_bank_o (fp_bank_o)
  );
endmodule

// File: tb/bankreg_core_tb.sv
module bankreg_core_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        gpr_we;
  logic [3:0]  gpr_waddr, gpr_raddr;
  logic [31:0] gpr_wdata, gpr_rdata;
  logic        sr_we;
  logic [31:0] sr_wdata, sr_rdata;
  logic        ctl_we;
  logic [1:0]  ctl_sel;
  logic [31:0] ctl_wdata;
  logic [31:0] pc_o, npc_o, vbr_o, fpscr_o;
  logic        fp_bank_o, bank_swap_o;

  always #2 clk = ~clk;

  bankreg_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .pc_o(pc_o), .npc_o(npc_o), .vbr_o(vbr_o), .fpscr_o(fpscr_o),
    .fp_bank_o(fp_bank_o), .bank_swap_o(bank_swap_o)
  );

  typedef enum int {K_GPR, K_SR, K_PC, K_NPC, K_VBR, K_FPSCR, K_FPB, K_SWAP} kind_e;
  typedef struct {
    kind_e       kind;
    string       req;
    logic [31:0] exp;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model built from the requirements
  logic [31:0] m_low [2][8];
  logic [31:0] m_hi  [8];
  logic        m_rb;
  logic [31:0] m_sr, m_vbr, m_fpscr, m_npc;
  logic        m_swap;

  // Monitor: samples 1 ns after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_GPR:   act = gpr_rdata;
        K_SR:    act = sr_rdata;
        K_PC:    act = pc_o;
        K_NPC:   act = npc_o;
        K_VBR:   act = vbr_o;
        K_FPSCR: act = fpscr_o;
        K_FPB:   act = {31'd0, fp_bank_o};
        default: act = {31'd0, bank_swap_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic idle_inputs();
    gpr_we = 0; sr_we = 0; ctl_we = 0;
  endtask

  task automatic drive(input bit gwe, input logic [3:0] ga, input logic [31:0] gd,
                       input bit swe, input logic [31:0] sv,
                       input bit cwe, input logic [1:0] cs, input logic [31:0] cd);
    @(negedge clk);
    gpr_we = gwe; gpr_waddr = ga; gpr_wdata = gd;
    sr_we = swe; sr_wdata = sv;
    ctl_we = cwe; ctl_sel = cs; ctl_wdata = cd;
    if (gwe) begin
      if (ga < 8) m_low[m_rb][ga[2:0]] = gd;
      else        m_hi[ga[2:0]] = gd;
    end
    m_swap = 0;
    if (swe) begin
      m_swap = (sv[29] != m_rb);
      m_rb   = sv[29];
      m_sr   = sv;
    end
    if (cwe) begin
      case (cs)
        2'd0: m_vbr = cd;
        2'd1: m_fpscr = cd;
        2'd2: m_npc = cd;
        default: ;
      endcase
    end
  endtask

  task automatic push(input kind_e k, input string r, input logic [31:0] e);
    item_t it;
    it.kind = k; it.req = r; it.exp = e;
    sb.push_back(it);
  endtask

  // Observe one general register in an idle cycle
  task automatic chk_gpr(input logic [3:0] a, input string r);
    @(negedge clk);
    idle_inputs();
    gpr_raddr = a;
    push(K_GPR, r, (a < 8) ? m_low[m_rb][a[2:0]] : m_hi[a[2:0]]);
    m_swap = 0;
  endtask

  // Observe the non-register outputs in an idle cycle
  task automatic chk_misc(input string r);
    @(negedge clk);
    idle_inputs();
    push(K_SWAP, r, {31'd0, m_swap});
    push(K_SR, r, m_sr);
    push(K_VBR, r, m_vbr);
    push(K_FPSCR, r, m_fpscr);
    push(K_NPC, r, m_npc);
    push(K_PC, r, m_npc - 32'd2);
    push(K_FPB, r, {31'd0, m_fpscr[21]});
    m_swap = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    gpr_waddr = 0; gpr_wdata = 0; gpr_raddr = 0;
    sr_wdata = 0; ctl_sel = 0; ctl_wdata = 0;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 8; i++) m_low[b][i] = 0;
    for (int i = 0; i < 8; i++) m_hi[i] = 0;
    m_rb = 0; m_sr = 0; m_vbr = 32'h0; m_fpscr = 32'h0004_0001; m_npc = 32'hA000_0002; m_swap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R7: reset values
    chk_misc("R7");
    chk_gpr(4'd3, "R7");
    chk_gpr(4'd12, "R7");

    // Fill all sixteen registers in bank 0
    for (int i = 0; i < 16; i++) drive(1, i[3:0], 32'h1000_0000 + i * 32'h111, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) chk_gpr(i[3:0], "R3");

    // R1/R9: bank change swaps R0..R7; R3: R8..R15 shared
    drive(0, 0, 0, 1, 32'h2000_0000, 0, 0, 0);
    chk_misc("R9");
    for (int i = 0; i < 16; i++) chk_gpr(i[3:0], (i < 8) ? "R1" : "R3");

    // R2: same bank bit, no swap; T flag set
    drive(1, 4'd2, 32'h0000_0055, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 32'h2000_0001, 0, 0, 0);
    chk_misc("R2");
    chk_gpr(4'd2, "R2");

    // R4: same-cycle write and bank change: data lands in old bank (1)
    drive(1, 4'd5, 32'hDEAD_BEEF, 1, 32'h0000_0000, 0, 0, 0);
    chk_misc("R4");
    chk_gpr(4'd5, "R4");
    drive(0, 0, 0, 1, 32'h2000_0000, 0, 0, 0);
    chk_gpr(4'd5, "R4");
    chk_gpr(4'd2, "R1");
    drive(0, 0, 0, 1, 32'h0000_0000, 0, 0, 0);
    chk_gpr(4'd0, "R1");

    // R5: flag positions T=0 S=1 Q=8 M=9
    drive(0, 0, 0, 1, 32'h0000_0303, 0, 0, 0);
    chk_misc("R5");
    drive(0, 0, 0, 1, 32'h0000_0102, 0, 0, 0);
    chk_misc("R5");
    // R6: other bits, mode/block bits, flags cleared by write
    drive(0, 0, 0, 1, 32'h5234_00FC, 0, 0, 0);
    chk_misc("R6");
    chk_misc("R6");
    drive(0, 0, 0, 1, 32'h1000_0000, 0, 0, 0);
    chk_misc("R6");

    // R8/R10: control loads and PC offset
    drive(0, 0, 0, 0, 0, 1, 2'd1, 32'h0024_0001);
    chk_misc("R8");
    drive(0, 0, 0, 0, 0, 1, 2'd0, 32'h8C00_0000);
    drive(0, 0, 0, 0, 0, 1, 2'd2, 32'h8C00_0100);
    chk_misc("R10");
    drive(0, 0, 0, 0, 0, 1, 2'd1, 32'h0004_0001);
    drive(0, 0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
    chk_misc("R10");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule